// File: doc/BRIEF.md
# Coprocessor Strobe-Handshake Byte Link Port

This block sits between a host and an external coprocessor and moves bytes in both directions through two 16-entry byte queues. The coprocessor does not share the system clock. It signals with a mode pin and two strobes: a rising edge on the shift-in strobe stores a byte in the upward (coprocessor-to-host) queue, and a falling edge on the shift-out strobe consumes a byte from the downward (host-to-coprocessor) queue. It sees two ready flags, one saying there is room to write and one saying there is data to read.

The shared 8-bit pad bus is handled as separate input, output and output-enable signals. While the mode pin is low, which is the idle state, the block drives the head of the downward queue onto the bus. The coprocessor can therefore sample the byte before it strobes it away. While the mode pin is high, the block releases the bus so the coprocessor can drive it. All three coprocessor controls pass through two-flop synchronizers, so each strobe level must be held for at least three system clocks.

The host side uses one-cycle request pulses. A push puts a byte into the downward queue, and a pop removes the head of the upward queue.

Top module: `cpl_link_port`

## Requirements
- R1: After reset both queues are empty: `cp_in_ready_o`=1, `cp_out_ready_o`=0, `host_rx_avail_o`=0, `host_tx_space_o`=1, `cp_data_oe_o`=1.
- R2: `cp_in_ready_o` is 1 exactly when the upward queue holds fewer than 16 bytes.
- R3: `cp_out_ready_o` is 1 exactly when the downward queue holds at least one byte.
- R4: A rising edge of `cp_shift_in_i` stores `cp_data_i` in the upward queue. A falling edge of that strobe stores nothing.
- R5: A falling edge of `cp_shift_out_n_i` removes the downward head. A rising edge removes nothing. While the queue is non-empty, `cp_data_o` shows the head.
- R6: `cp_data_oe_o` is 0 while the synchronized mode pin is 1 and is 1 while it is 0. A change on `cp_wr_mode_i` made before clock edge k reaches `cp_data_oe_o` after edge k+1.
- R7: A store request on a full queue, from either side, is ignored and leaves the contents unchanged.
- R8: A removal request on an empty queue, from either side, is ignored.
- R9: While the downward queue is empty, `cp_data_o` holds the byte most recently removed from it.
- R10: A strobe edge made before clock edge k updates the queue and its flags after edge k+2, and not earlier.
- R11: `host_push_i` stores `host_push_data_i` in the downward queue at the next edge. `host_pop_i` removes the upward head, which is shown on `host_pop_data_o`. `host_rx_avail_o` means the upward queue is non-empty, and `host_tx_space_o` means the downward queue is not full.
- R12: Both queues deliver bytes in the order they were stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, empties both queues |
| cp_wr_mode_i | input | 1 | Coprocessor mode: 1 = it drives the bus, 0 = block drives it |
| cp_shift_in_i | input | 1 | Asynchronous store strobe, active on its rising edge |
| cp_shift_out_n_i | input | 1 | Asynchronous remove strobe, active on its falling edge |
| cp_data_i | input | 8 | Bus value from the pad |
| cp_data_o | output | 8 | Value the block drives toward the pad |
| cp_data_oe_o | output | 1 | Pad output enable |
| cp_in_ready_o | output | 1 | Upward queue has room |
| cp_out_ready_o | output | 1 | Downward queue has data |
| host_push_i | input | 1 | One-cycle host store request |
| host_push_data_i | input | 8 | Byte for the downward queue |
| host_pop_i | input | 1 | One-cycle host removal request |
| host_pop_data_o | output | 8 | Upward queue head |
| host_rx_avail_o | output | 1 | Upward queue non-empty |
| host_tx_space_o | output | 1 | Downward queue not full |

## Verification
Results on the coprocessor side are due after the third rising clock edge that follows a strobe change, and the output-enable response is due after the second edge that follows a mode change. Host requests take effect at the first edge. The bench drives every input on a falling clock edge. For the coprocessor-side latency it samples after two edges and again after three, so that both an early result and a late result are caught. Other checks wait at least four edges after a strobe change before sampling, so that they compare only settled values.

// File: rtl/cpl_pkg.sv
package cpl_pkg;
    parameter int BYTE_W  = 8;
    parameter int Q_DEPTH = 16;

    typedef struct packed {
        logic wr_mode;
        logic shift_in;
        logic shift_out_n;
    } cp_ctl_t;
endpackage

// File: rtl/cpl_sync.sv
module cpl_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/cpl_byte_queue.sv
module cpl_byte_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } q_st_t;

    q_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (st_q.cnt == CW'(DEPTH));
    assign empty_o = (st_q.cnt == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = mem[st_q.rd];

    always_comb begin
        st_d = st_q;
        if (do_push) st_d.wr = bump(st_q.wr);
        if (do_pop)  st_d.rd = bump(st_q.rd);
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wr] <= data_i;
    end

    // R7: occupancy never exceeds the depth
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R7: a full queue with no removal stays full and keeps its write pointer
    assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !pop_i) |=> (full_o && $stable(st_q.wr)));

    // R8: an empty queue with no store stays empty
    assert_empty_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/cpl_link_port.sv
module cpl_link_port
    import cpl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cp_wr_mode_i,
    input  logic              cp_shift_in_i,
    input  logic              cp_shift_out_n_i,
    input  logic [BYTE_W-1:0] cp_data_i,
    output logic [BYTE_W-1:0] cp_data_o,
    output logic              cp_data_oe_o,
    output logic              cp_in_ready_o,
    output logic              cp_out_ready_o,
    input  logic              host_push_i,
    input  logic [BYTE_W-1:0] host_push_data_i,
    input  logic              host_pop_i,
    output logic [BYTE_W-1:0] host_pop_data_o,
    output logic              host_rx_avail_o,
    output logic              host_tx_space_o
);
    typedef struct packed {
        cp_ctl_t           prev;
        logic [BYTE_W-1:0] last;
    } port_st_t;

    port_st_t st_d, st_q;
    cp_ctl_t  ctl_s;
    logic     si_rise, so_fall;
    logic     up_full, up_empty, dn_full, dn_empty;
    logic [BYTE_W-1:0] dn_head;

    cpl_sync #(.N($bits(cp_ctl_t))) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cp_wr_mode_i, cp_shift_in_i, cp_shift_out_n_i}),
        .sync_o  (ctl_s)
    );

    assign si_rise = ctl_s.shift_in && !st_q.prev.shift_in;
    assign so_fall = !ctl_s.shift_out_n && st_q.prev.shift_out_n;

    cpl_byte_queue #(.W(BYTE_W), .DEPTH(Q_DEPTH)) u_up_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (si_rise),
        .data_i  (cp_data_i),
        .pop_i   (host_pop_i),
        .head_o  (host_pop_data_o),
        .full_o  (up_full),
        .empty_o (up_empty)
    );

    cpl_byte_queue #(.W(BYTE_W), .DEPTH(Q_DEPTH)) u_dn_q (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (host_push_i),
        .data_i  (host_push_data_i),
        .pop_i   (so_fall),
        .head_o  (dn_head),
        .full_o  (dn_full),
        .empty_o (dn_empty)
    );

    always_comb begin
        st_d      = st_q;
        st_d.prev = ctl_s;
        if (so_fall && !dn_empty) st_d.last = dn_head;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cp_data_o       = dn_empty ? st_q.last : dn_head;
    assign cp_data_oe_o    = !ctl_s.wr_mode;
    assign cp_in_ready_o   = !up_full;
    assign cp_out_ready_o  = !dn_empty;
    assign host_rx_avail_o = !up_empty;
    assign host_tx_space_o = !dn_full;

    // R2: room disappears only through a coprocessor store edge
    assert_room_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cp_in_ready_o) |-> $past(si_rise));

    // R3: data appears for the coprocessor only through a host store
    assert_data_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cp_out_ready_o) |-> $past(host_push_i));

    // R5: data disappears only through a shift-out falling edge
    assert_data_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cp_out_ready_o) |-> $past(so_fall));

    // R9: the bus value holds while the downward queue stays empty
    assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_out_ready_o && $past(!cp_out_ready_o)) |-> $stable(cp_data_o));
endmodule

// File: tb/cpl_link_port_tb.sv
module cpl_link_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_mode = 1'b0, si = 1'b0, so_n = 1'b0;
    logic [7:0] cp_din = 8'h00;
    logic [7:0] cp_dout;
    logic       oe, in_rdy, out_rdy;
    logic       h_push = 1'b0, h_pop = 1'b0;
    logic [7:0] h_pdata = 8'h00;
    logic [7:0] h_rdata;
    logic       rx_avail, tx_space;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cpl_link_port u_dut (
        .clk(clk), .rst_n(rst_n),
        .cp_wr_mode_i(wr_mode), .cp_shift_in_i(si), .cp_shift_out_n_i(so_n),
        .cp_data_i(cp_din), .cp_data_o(cp_dout), .cp_data_oe_o(oe),
        .cp_in_ready_o(in_rdy), .cp_out_ready_o(out_rdy),
        .host_push_i(h_push), .host_push_data_i(h_pdata),
        .host_pop_i(h_pop), .host_pop_data_o(h_rdata),
        .host_rx_avail_o(rx_avail), .host_tx_space_o(tx_space)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cp_write(input logic [7:0] b);
        cp_din = b; step(1);
        si = 1'b1; step(4);
        si = 1'b0; step(4);
    endtask

    task automatic cp_read_pulse;
        so_n = 1'b1; step(4);
        so_n = 1'b0; step(4);
    endtask

    task automatic host_push(input logic [7:0] b);
        h_pdata = b; h_push = 1'b1; step(1);
        h_push = 1'b0;
    endtask

    task automatic host_pop;
        h_pop = 1'b1; step(1);
        h_pop = 1'b0;
    endtask

    task automatic t_reset;
        chk(in_rdy == 1'b1,   "R1 in_ready",  in_rdy, 1);
        chk(out_rdy == 1'b0,  "R1 out_ready", out_rdy, 0);
        chk(rx_avail == 1'b0, "R1 rx_avail",  rx_avail, 0);
        chk(tx_space == 1'b1, "R1 tx_space",  tx_space, 1);
        chk(oe == 1'b1,       "R1 oe",        oe, 1);
    endtask

    task automatic t_downward;
        host_push(8'hA1); host_push(8'hB2); host_push(8'hC3);
        chk(out_rdy == 1'b1, "R3 out_ready set", out_rdy, 1);
        chk(cp_dout == 8'hA1, "R5 head on bus", cp_dout, 8'hA1);
        so_n = 1'b1; step(4);
        chk(cp_dout == 8'hA1, "R5 rising edge no pop", cp_dout, 8'hA1);
        so_n = 1'b0; step(4);
        chk(cp_dout == 8'hB2, "R12 second byte", cp_dout, 8'hB2);
        cp_read_pulse();
        chk(cp_dout == 8'hC3, "R12 third byte", cp_dout, 8'hC3);
        cp_read_pulse();
        chk(out_rdy == 1'b0, "R3 out_ready clear", out_rdy, 0);
        chk(cp_dout == 8'hC3, "R9 last byte held", cp_dout, 8'hC3);
        cp_read_pulse();
        chk(out_rdy == 1'b0, "R8 empty pop ignored", out_rdy, 0);
        chk(cp_dout == 8'hC3, "R8 R9 bus unchanged", cp_dout, 8'hC3);
        host_push(8'h5E);
        chk(cp_dout == 8'h5E, "R8 new head after empty pop", cp_dout, 8'h5E);
        cp_read_pulse();
    endtask

    task automatic t_latency;
        cp_din = 8'h77; step(1);
        si = 1'b1; step(2);
        chk(rx_avail == 1'b0, "R10 not before third edge", rx_avail, 0);
        step(1);
        chk(rx_avail == 1'b1, "R10 after third edge", rx_avail, 1);
        chk(h_rdata == 8'h77, "R4 byte stored", h_rdata, 8'h77);
        step(3);
        si = 1'b0; step(4);
        chk(rx_avail == 1'b1, "R4 falling edge no store", rx_avail, 1);
        host_pop();
        chk(rx_avail == 1'b0, "R11 host pop empties", rx_avail, 0);
    endtask

    task automatic t_upward_full;
        for (int i = 0; i < 16; i++) begin
            chk(in_rdy == 1'b1, "R2 room before full", in_rdy, 1);
            cp_write(8'(8'h10 + i));
        end
        chk(in_rdy == 1'b0, "R2 full clears in_ready", in_rdy, 0);
        cp_write(8'hEE);
        host_pop();
        chk(in_rdy == 1'b1, "R2 room after host pop", in_rdy, 1);
        for (int i = 1; i < 16; i++) begin
            chk(h_rdata == 8'(8'h10 + i), "R12 upward order", h_rdata, 8'h10 + i);
            host_pop();
        end
        chk(rx_avail == 1'b0, "R7 overflow byte dropped", rx_avail, 0);
        host_pop();
        chk(rx_avail == 1'b0 && in_rdy == 1'b1, "R8 host pop on empty", rx_avail, 0);
    endtask

    task automatic t_downward_full;
        for (int i = 0; i < 16; i++) host_push(8'(8'h80 + i));
        chk(tx_space == 1'b0, "R11 tx_space clear when full", tx_space, 0);
        host_push(8'hFF);
        for (int i = 0; i < 16; i++) begin
            chk(cp_dout == 8'(8'h80 + i), "R7 R12 downward order", cp_dout, 8'h80 + i);
            cp_read_pulse();
        end
        chk(out_rdy == 1'b0, "R7 extra host byte dropped", out_rdy, 0);
        chk(tx_space == 1'b1, "R11 tx_space restored", tx_space, 1);
    endtask

    task automatic t_mode;
        wr_mode = 1'b1; step(1);
        chk(oe == 1'b1, "R6 oe not yet released", oe, 1);
        step(1);
        chk(oe == 1'b0, "R6 bus released", oe, 0);
        wr_mode = 1'b0; step(2);
        chk(oe == 1'b1, "R6 bus driven again", oe, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_downward();
        t_latency();
        t_upward_full();
        t_downward_full();
        t_mode();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule